// File: doc/BRIEF.md
# UDP Stream Frame Transmitter

This block turns a continuous stream of captured data bytes into complete Ethernet frames carrying IPv4/UDP datagrams. It sends them to a 100 Mbit/s PHY over a 4-bit transmit-nibble interface, and no processor is involved. Bytes arrive on a valid/ready byte port and are held in an internal payload FIFO. When the FIFO holds one full payload of the configured length, the block sends one frame: preamble and start delimiter, a 42-byte header, the payload, zero padding if needed, and the CRC-32 frame check sequence. It then holds the line idle for an inter-frame gap.

The header comes from a template. The source MAC, source IP and source port are fixed by parameters. The destination MAC, destination IP, destination port and payload length come from configuration inputs, which are captured when each frame starts. The IPv4 total length, the UDP length and the IPv4 header checksum are derived from the captured length. The UDP checksum is always sent as zero, so the receiver skips that check. Frames are fire-and-forget: nothing is acknowledged or resent.

Top module: `udp_frame_tx`

## Requirements
- R1: While reset is applied and just after it is released, `mii_txen` is 0, `mii_txd` is 0 and `in_ready` is 1.
- R2: Every frame begins with seven 0x55 bytes followed by one 0xD5 byte. Every byte on `mii_txd` is sent as two nibbles on consecutive cycles, bits [3:0] first, while `mii_txen` is 1.
- R3: Bytes 0..41 after the start delimiter are laid out as follows. Bytes 0..5 are the destination MAC, most significant byte first. Bytes 6..11 are the source MAC. Bytes 12..13 are 0x0800. Bytes 14..15 are 0x45 0x00. Bytes 16..17 are the IP total length, payload+28. Bytes 18..19 are 0. Bytes 20..21 are 0x40 0x00. Byte 22 is 64 and byte 23 is 0x11. Bytes 24..25 are the header checksum. Bytes 26..29 are the source IP and bytes 30..33 the destination IP. Bytes 34..35 are the source port and bytes 36..37 the destination port. Bytes 38..39 are the UDP length, payload+8. Bytes 40..41 are the UDP checksum and are always 0. All multi-byte fields are big-endian.
- R4: The IPv4 header checksum is valid: the ones-complement sum of the ten 16-bit words of bytes 14..33 equals 0xFFFF. It follows any change of the configured length from one frame to the next.
- R5: Payload bytes follow the header in the order they were accepted. Each frame takes exactly the configured number of bytes.
- R6: If header plus payload is shorter than 60 bytes, zero bytes are added until it reaches 60, so a frame is never shorter than 64 bytes including the FCS.
- R7: The last four bytes are the reflected CRC-32 (polynomial 0x04C11DB7, initial value all ones, result inverted) over the header, payload and padding, sent least significant byte first.
- R8: A frame starts only when the FIFO holds at least the configured payload length and that length is non-zero. A length of zero sends nothing.
- R9: `mii_txen` stays low for at least 24 cycles between consecutive frames.
- R10: When the FIFO holds DEPTH bytes, `in_ready` is 0 and offered bytes are not taken; they never appear in any frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, one nibble per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | `in_data` is offered |
| in_ready | output | 1 | Byte is taken on this edge when `in_valid` is 1 |
| cfg_len | input | $clog2(DEPTH+1) | Payload bytes per frame |
| cfg_dst_mac | input | 48 | Destination MAC address |
| cfg_dst_ip | input | 32 | Destination IPv4 address |
| cfg_dst_port | input | 16 | Destination UDP port |
| mii_txd | output | 4 | Transmit nibble |
| mii_txen | output | 1 | Transmit enable |

## Verification
`in_ready` falls on the edge that accepts the byte that fills the FIFO, so the bench reads it at the next falling edge. It counts a byte as taken only if `in_ready` was high when that byte was presented. `mii_txen` rises two edges after the edge that accepts the last byte of a full payload: one register for the state machine and one for the output nibble. The bench samples nibbles on the falling edge from that point, one nibble per cycle, and rebuilds each byte from two consecutive samples. Each frame is compared field by field against bytes the bench builds itself once `mii_txen` has fallen, which is well before the next frame can start. The idle gap is counted in falling-edge samples of `mii_txen` between frames.

// File: rtl/udp_tx_pkg.sv
package udp_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_HDR, ST_PAY, ST_PAD, ST_FCS, ST_GAP
  } tx_state_t;

  localparam int PRE_BYTES = 8;
  localparam int HDR_BYTES = 42;
  localparam int MIN_DATA  = 60;
  localparam int FCS_BYTES = 4;
  localparam int GAP_CYC   = 24;

  // reflected CRC-32, one byte, LSB first
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/udp_tx_fifo.sv
module udp_tx_fifo #(
  parameter int DEPTH = 256
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [7:0]                     wr_data,
  input  logic                           rd_en,
  output logic [7:0]                     rd_data,
  output logic [$clog2(DEPTH+1)-1:0]     level,
  output logic                           full
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [LW-1:0] lvl_q, lvl_d;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_q] <= wr_data;
  end

  always_comb begin
    lvl_d = lvl_q;
    if (wr_en && !rd_en) lvl_d = lvl_q + 1'b1;
    else if (rd_en && !wr_en) lvl_d = lvl_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (wr_en) wp_q <= wp_q + 1'b1;
      if (rd_en) rp_q <= rp_q + 1'b1;
      lvl_q <= lvl_d;
    end
  end

  assign rd_data = mem[rp_q];
  assign level   = lvl_q;
  assign full    = (lvl_q == LW'(DEPTH));
endmodule

// File: rtl/udp_tx_hdr.sv
module udp_tx_hdr #(
  parameter int          LEN_W    = 9,
  parameter logic [47:0] SRC_MAC  = 48'h0200_0000_0001,
  parameter logic [31:0] SRC_IP   = 32'hC0A8_0001,
  parameter logic [15:0] SRC_PORT = 16'd5000
) (
  input  logic [5:0]       idx,
  input  logic [LEN_W-1:0] len,
  input  logic [47:0]      dst_mac,
  input  logic [31:0]      dst_ip,
  input  logic [15:0]      dst_port,
  output logic [7:0]       hdr_byte
);
  localparam int NB = 42;

  logic [15:0]     ip_len, udp_len, csum;
  logic [19:0]     sum0;
  logic [16:0]     sum1;
  logic [16:0]     sum2;
  logic [NB*8-1:0] tmpl;

  always_comb begin
    ip_len  = 16'(len) + 16'd28;
    udp_len = 16'(len) + 16'd8;
    sum0 = 20'h4500 + 20'(ip_len) + 20'h4000 + 20'h4011
         + 20'(SRC_IP[31:16]) + 20'(SRC_IP[15:0])
         + 20'(dst_ip[31:16]) + 20'(dst_ip[15:0]);
    sum1 = 17'(sum0[15:0]) + 17'(sum0[19:16]);
    sum2 = 17'(sum1[15:0]) + 17'(sum1[16]);
    csum = ~sum2[15:0];
    tmpl = {dst_mac, SRC_MAC, 16'h0800,
            16'h4500, ip_len, 16'h0000, 16'h4000, 8'd64, 8'h11, csum,
            SRC_IP, dst_ip,
            SRC_PORT, dst_port, udp_len, 16'h0000};
    hdr_byte = tmpl[(NB-1-int'(idx))*8 +: 8];
  end
endmodule

// File: rtl/udp_tx_crc.sv
module udp_tx_crc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  data,
  output logic [31:0] crc
);
  import udp_tx_pkg::*;
  logic [31:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (init)    crc_d = 32'hFFFF_FFFF;
    else if (en) crc_d = crc32_step(crc_q, data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= 32'hFFFF_FFFF;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/udp_frame_tx.sv
module udp_frame_tx #(
  parameter int          DEPTH    = 256,
  parameter logic [47:0] SRC_MAC  = 48'h0200_0000_0001,
  parameter logic [31:0] SRC_IP   = 32'hC0A8_0001,
  parameter logic [15:0] SRC_PORT = 16'd5000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [7:0]                 in_data,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [$clog2(DEPTH+1)-1:0] cfg_len,
  input  logic [47:0]                cfg_dst_mac,
  input  logic [31:0]                cfg_dst_ip,
  input  logic [15:0]                cfg_dst_port,
  output logic [3:0]                 mii_txd,
  output logic                       mii_txen
);
  import udp_tx_pkg::*;

  localparam int LEN_W = $clog2(DEPTH+1);
  localparam logic [LEN_W-1:0] PAD_LIM = LEN_W'(MIN_DATA - HDR_BYTES);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  tx_state_t        st_q, st_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             half_q, half_d;
  logic [LEN_W-1:0] len_q;
  logic [47:0]      mac_q;
  logic [31:0]      ip_q;
  logic [15:0]      port_q;
  logic             start;

  logic [LEN_W-1:0] fifo_cnt;
  logic             fifo_full, fifo_pop;
  logic [7:0]       fifo_q, hdr_b, cur_b;
  logic [31:0]      crc_q, fcs;
  logic             crc_en, active;
  logic [3:0]       txd_q;
  logic             txen_q;

  assign in_ready = !fifo_full;

  udp_tx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_s_n),
    .wr_en(in_valid && !fifo_full), .wr_data(in_data),
    .rd_en(fifo_pop), .rd_data(fifo_q),
    .level(fifo_cnt), .full(fifo_full)
  );

  udp_tx_hdr #(.LEN_W(LEN_W), .SRC_MAC(SRC_MAC), .SRC_IP(SRC_IP), .SRC_PORT(SRC_PORT)) u_hdr (
    .idx(cnt_q[5:0]), .len(len_q), .dst_mac(mac_q), .dst_ip(ip_q),
    .dst_port(port_q), .hdr_byte(hdr_b)
  );

  udp_tx_crc u_crc (
    .clk(clk), .rst_n(rst_s_n), .init(st_q == ST_PRE), .en(crc_en),
    .data(cur_b), .crc(crc_q)
  );

  assign start    = (st_q == ST_IDLE) && (cfg_len != '0) && (fifo_cnt >= cfg_len);
  assign fifo_pop = (st_q == ST_PAY) && half_q;
  assign crc_en   = half_q && (st_q inside {ST_HDR, ST_PAY, ST_PAD});
  assign active   = st_q inside {ST_PRE, ST_HDR, ST_PAY, ST_PAD, ST_FCS};
  assign fcs      = ~crc_q;

  always_comb begin
    unique case (st_q)
      ST_PRE:  cur_b = (cnt_q == LEN_W'(PRE_BYTES-1)) ? 8'hD5 : 8'h55;
      ST_HDR:  cur_b = hdr_b;
      ST_PAY:  cur_b = fifo_q;
      ST_FCS:  cur_b = fcs[cnt_q[1:0]*8 +: 8];
      default: cur_b = 8'h00;
    endcase
  end

  // next state
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    half_d = active ? !half_q : 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin st_d = ST_PRE; cnt_d = '0; end
      ST_PRE: if (half_q) begin
        if (cnt_q == LEN_W'(PRE_BYTES-1)) begin st_d = ST_HDR; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      ST_HDR: if (half_q) begin
        if (cnt_q == LEN_W'(HDR_BYTES-1)) begin st_d = ST_PAY; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      ST_PAY: if (half_q) begin
        if (cnt_q == len_q - 1'b1) begin
          st_d  = (len_q < PAD_LIM) ? ST_PAD : ST_FCS;
          cnt_d = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_PAD: if (half_q) begin
        if (cnt_q == PAD_LIM - len_q - 1'b1) begin st_d = ST_FCS; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      ST_FCS: if (half_q) begin
        if (cnt_q == LEN_W'(FCS_BYTES-1)) begin st_d = ST_GAP; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      ST_GAP: begin
        if (cnt_q == LEN_W'(GAP_CYC-1)) begin st_d = ST_IDLE; cnt_d = '0; end
        else cnt_d = cnt_q + 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      half_q <= 1'b0;
      len_q  <= '0;
      mac_q  <= '0;
      ip_q   <= '0;
      port_q <= '0;
      txd_q  <= '0;
      txen_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      half_q <= half_d;
      if (start) begin
        len_q  <= cfg_len;
        mac_q  <= cfg_dst_mac;
        ip_q   <= cfg_dst_ip;
        port_q <= cfg_dst_port;
      end
      txd_q  <= active ? (half_q ? cur_b[7:4] : cur_b[3:0]) : 4'h0;
      txen_q <= active;
    end
  end

  assign mii_txd  = txd_q;
  assign mii_txen = txen_q;
endmodule

// File: rtl/udp_tx_chk.sv
module udp_tx_chk #(
  parameter int DEPTH = 256
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       mii_txen,
  input logic [3:0]                 mii_txd,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic [$clog2(DEPTH+1)-1:0] fifo_cnt,
  input logic [$clog2(DEPTH+1)-1:0] cfg_len
);
  logic [7:0]  gap_c;
  logic [11:0] nib_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_c <= 8'd24;
      nib_c <= '0;
    end else if (mii_txen) begin
      gap_c <= '0;
      nib_c <= nib_c + 1'b1;
    end else begin
      gap_c <= (gap_c == 8'hFF) ? gap_c : gap_c + 1'b1;
      nib_c <= '0;
    end
  end

  // R2
  preamble_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mii_txen) |-> mii_txd == 4'h5);

  // R9
  ifg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mii_txen) |-> gap_c >= 8'd24);

  // R6
  min_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mii_txen) |-> nib_c >= 12'd144);

  // R8
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mii_txen) |-> ($past(fifo_cnt, 2) >= $past(cfg_len, 2)) && ($past(cfg_len, 2) != 0));

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= ($clog2(DEPTH+1))'(DEPTH));

  // R10
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> fifo_cnt <= $past(fifo_cnt));
endmodule

bind udp_frame_tx udp_tx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mii_txen(mii_txen), .mii_txd(mii_txd),
  .in_valid(in_valid), .in_ready(in_ready), .fifo_cnt(fifo_cnt), .cfg_len(cfg_len)
);

// File: tb/udp_frame_tx_bench.sv
`timescale 1ns/1ps
module udp_frame_tx_bench;
  localparam int          DEPTH = 256;
  localparam int          LW    = $clog2(DEPTH+1);
  localparam logic [47:0] SMAC  = 48'h0200_0000_0001;
  localparam logic [31:0] SIP   = 32'hC0A8_0001;
  localparam logic [15:0] SPORT = 16'd5000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    in_data = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [LW-1:0] cfg_len = '0;
  logic [47:0]   cfg_dst_mac = 48'h0A1B_2C3D_4E5F;
  logic [31:0]   cfg_dst_ip = 32'hC0A8_0064;
  logic [15:0]   cfg_dst_port = 16'd6000;
  logic [3:0]    mii_txd;
  logic          mii_txen;

  always #2.5 clk = ~clk;

  udp_frame_tx #(.DEPTH(DEPTH), .SRC_MAC(SMAC), .SRC_IP(SIP), .SRC_PORT(SPORT)) u_udp_frame_tx (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .cfg_len(cfg_len), .cfg_dst_mac(cfg_dst_mac), .cfg_dst_ip(cfg_dst_ip),
    .cfg_dst_port(cfg_dst_port), .mii_txd(mii_txd), .mii_txen(mii_txen)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // ---------------- monitor ----------------
  logic [7:0] cap [0:1023];
  int nib = 0, last_len = 0, frames_done = 0, idle = 0, min_gap = 9999;
  bit prev_en = 0, seen = 0;

  always @(negedge clk) begin
    if (mii_txen) begin
      if (!prev_en) begin
        nib = 0;
        if (seen && idle < min_gap) min_gap = idle;
      end
      if (nib < 2048) begin
        if (nib % 2 == 0) cap[nib/2][3:0] = mii_txd;
        else              cap[nib/2][7:4] = mii_txd;
      end
      nib++;
      idle = 0;
    end else begin
      if (prev_en) begin
        last_len = nib / 2;
        frames_done++;
        seen = 1;
      end
      idle++;
    end
    prev_en = mii_txen;
  end

  // ---------------- expected frame ----------------
  logic [7:0] exp_b [0:1023];
  int exp_n;

  function automatic logic [31:0] ref_crc(input int first, input int last);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = first; k <= last; k++) begin
      for (int b = 0; b < 8; b++) begin
        if (c[0] ^ exp_b[k][b]) c = (c >> 1) ^ 32'hEDB8_8320;
        else                    c = c >> 1;
      end
    end
    return ~c;
  endfunction

  task automatic build_exp(input int len, input logic [7:0] seed);
    int p;
    logic [31:0] f;
    logic [15:0] tl, ul;
    tl = 16'(len + 28);
    ul = 16'(len + 8);
    for (int k = 0; k < 7; k++) exp_b[k] = 8'h55;
    exp_b[7] = 8'hD5;
    for (int k = 0; k < 6; k++) exp_b[8+k]  = cfg_dst_mac[47-8*k -: 8];
    for (int k = 0; k < 6; k++) exp_b[14+k] = SMAC[47-8*k -: 8];
    exp_b[20] = 8'h08; exp_b[21] = 8'h00;
    exp_b[22] = 8'h45; exp_b[23] = 8'h00;
    exp_b[24] = tl[15:8]; exp_b[25] = tl[7:0];
    exp_b[26] = 8'h00; exp_b[27] = 8'h00;
    exp_b[28] = 8'h40; exp_b[29] = 8'h00;
    exp_b[30] = 8'd64; exp_b[31] = 8'h11;
    exp_b[32] = 8'h00; exp_b[33] = 8'h00;   // checksum checked separately
    for (int k = 0; k < 4; k++) exp_b[34+k] = SIP[31-8*k -: 8];
    for (int k = 0; k < 4; k++) exp_b[38+k] = cfg_dst_ip[31-8*k -: 8];
    exp_b[42] = SPORT[15:8]; exp_b[43] = SPORT[7:0];
    exp_b[44] = cfg_dst_port[15:8]; exp_b[45] = cfg_dst_port[7:0];
    exp_b[46] = ul[15:8]; exp_b[47] = ul[7:0];
    exp_b[48] = 8'h00; exp_b[49] = 8'h00;
    p = 50;
    for (int k = 0; k < len; k++) begin exp_b[p] = 8'(seed + k); p++; end
    while (p < 68) begin exp_b[p] = 8'h00; p++; end
    exp_b[32] = cap[32]; exp_b[33] = cap[33];  // CRC must include the sent checksum
    f = ref_crc(8, p-1);
    for (int k = 0; k < 4; k++) begin exp_b[p] = f[8*k +: 8]; p++; end
    exp_n = p;
  endtask

  task automatic check_frame(input int len, input logic [7:0] seed, input string tag);
    int bad;
    logic [19:0] s;
    logic [16:0] s1;
    build_exp(len, seed);
    // R6 total length (preamble + at least 64)
    chk(last_len == exp_n, {"R6 frame length ", tag}, last_len, exp_n);
    bad = -1;
    for (int k = 0; k < 8; k++) if (bad < 0 && cap[k] != exp_b[k]) bad = k;
    // R2
    chk(bad < 0, {"R2 preamble/SFD ", tag}, bad < 0 ? 0 : cap[bad], bad < 0 ? 0 : exp_b[bad]);
    bad = -1;
    for (int k = 8; k < 50; k++) if (bad < 0 && cap[k] != exp_b[k]) bad = k;
    // R3
    chk(bad < 0, {"R3 header fields ", tag}, bad < 0 ? 0 : cap[bad], bad < 0 ? 0 : exp_b[bad]);
    s = 0;
    for (int k = 0; k < 10; k++) s += 20'({cap[22+2*k], cap[23+2*k]});
    s1 = 17'(s[15:0]) + 17'(s[19:16]);
    s1 = 17'(s1[15:0]) + 17'(s1[16]);
    // R4
    chk(s1[15:0] == 16'hFFFF, {"R4 ip checksum ", tag}, s1[15:0], 16'hFFFF);
    bad = -1;
    for (int k = 50; k < 50 + len; k++) if (bad < 0 && cap[k] != exp_b[k]) bad = k;
    // R5
    chk(bad < 0, {"R5 payload ", tag}, bad < 0 ? 0 : cap[bad], bad < 0 ? 0 : exp_b[bad]);
    if (len < 18) begin
      bad = -1;
      for (int k = 50 + len; k < 68; k++) if (bad < 0 && cap[k] != 8'h00) bad = k;
      // R6 padding zero
      chk(bad < 0, {"R6 padding ", tag}, bad < 0 ? 0 : cap[bad], 0);
    end
    // R7
    chk({cap[exp_n-1], cap[exp_n-2], cap[exp_n-3], cap[exp_n-4]} ==
        {exp_b[exp_n-1], exp_b[exp_n-2], exp_b[exp_n-3], exp_b[exp_n-4]},
        {"R7 fcs ", tag},
        {cap[exp_n-1], cap[exp_n-2], cap[exp_n-3], cap[exp_n-4]},
        {exp_b[exp_n-1], exp_b[exp_n-2], exp_b[exp_n-3], exp_b[exp_n-4]});
  endtask

  // ---------------- drivers ----------------
  task automatic push(input int n, input logic [7:0] seed, output int taken);
    taken = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'(seed + k);
      if (in_ready) taken++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_frames(input int target);
    int t = 0;
    while (frames_done < target && t < 5000) begin
      @(posedge clk);
      t++;
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(mii_txen == 0 && mii_txd == 0 && in_ready == 1, "R1 in reset", {mii_txen, mii_txd, in_ready}, 5'b00001);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(mii_txen == 0 && mii_txd == 0 && in_ready == 1, "R1 after release", {mii_txen, mii_txd, in_ready}, 5'b00001);
  endtask

  task automatic t_hold_then_send();
    int tk, f0;
    bit rose = 0;
    f0 = frames_done;
    cfg_len = LW'(30);
    push(29, 8'h10, tk);
    for (int k = 0; k < 60; k++) begin @(negedge clk); if (mii_txen) rose = 1; end
    // R8 partial payload must not start a frame
    chk(!rose, "R8 no start on partial payload", rose, 0);
    push(1, 8'h10 + 8'd29, tk);
    wait_frames(f0 + 1);
    chk(frames_done == f0 + 1, "R8 frame after full payload", frames_done - f0, 1);
    check_frame(30, 8'h10, "len30");
  endtask

  task automatic t_short_pad();
    int tk, f0;
    f0 = frames_done;
    cfg_dst_mac  = 48'hFFEE_DDCC_BBAA;
    cfg_dst_port = 16'd1234;
    cfg_len = LW'(5);
    push(5, 8'hA0, tk);
    wait_frames(f0 + 1);
    check_frame(5, 8'hA0, "len5");
  endtask

  task automatic t_burst();
    int tk, f0;
    f0 = frames_done;
    min_gap = 9999;
    cfg_dst_ip = 32'h0A00_0007;
    cfg_len = LW'(20);
    push(60, 8'h40, tk);
    for (int j = 0; j < 3; j++) begin
      wait_frames(f0 + j + 1);
      check_frame(20, 8'(8'h40 + 20*j), $sformatf("burst%0d", j));
    end
    // R9
    chk(min_gap >= 24, "R9 inter-frame gap", min_gap, 24);
  endtask

  task automatic t_full_and_zero();
    int tk, f0;
    f0 = frames_done;
    cfg_len = '0;
    push(DEPTH + 6, 8'h03, tk);
    // R10
    chk(tk == DEPTH, "R10 bytes taken when full", tk, DEPTH);
    chk(in_ready == 0, "R10 in_ready low when full", in_ready, 0);
    repeat (40) @(negedge clk);
    // R8 zero length sends nothing
    chk(frames_done == f0 && !mii_txen, "R8 zero length idle", frames_done - f0, 0);
    cfg_len = LW'(DEPTH);
    wait_frames(f0 + 1);
    check_frame(DEPTH, 8'h03, "full");
    @(negedge clk);
    chk(in_ready == 1, "R10 in_ready after drain", in_ready, 1);
  endtask

  initial begin
    t_reset();
    t_hold_then_send();
    t_short_pad();
    t_burst();
    t_full_and_zero();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule